// File: doc/BRIEF.md
# Gated-Clock Synchronous Serial Port

This block moves parallel words over a three-wire synchronous serial link in which the bit clock only runs while a word is on the wire. No frame-sync signal exists; a word is delimited purely by a burst of exactly as many clock pulses as the configured word length. Each pulse has a leading edge, on which the block presents the next transmit bit (most significant bit first), and a trailing edge, on which it samples the receive line. The polarity setting picks which physical edge leads and also fixes the level the clock must rest at between bursts.

As clock master the block divides the system clock down to the bit rate and drives the clock pin, holding it at the idle level between words. As clock slave it arms a transmit word and then waits for edges on the clock input, which it brings into the system clock domain with a two-stage synchronizer and an edge detector. Words enter through a valid/ready handshake and leave through a data bus with a one-cycle strobe. A sticky error flag catches an idle-level setting that contradicts the polarity and blocks new transfers until reset.

The controller is a four-state machine: ST_IDLE (waiting for a word; a handshake moves to ST_LEAD), ST_LEAD (clock at rest; a leading edge drives a bit and moves to ST_TRAIL), ST_TRAIL (clock active; a trailing edge samples a bit and moves back to ST_LEAD, or to ST_DONE after the last bit), and ST_DONE (one cycle presenting the received word, then back to ST_IDLE).

Top module: `gated_serial_port`

## Requirements
- R1: In master mode (cfg_master=1) one word produces exactly as many clock pulses as the effective word length, with a leading-to-leading edge period of 2*max(cfg_half,1) system cycles; sck_oe equals cfg_master.
- R2: In master mode the clock pin rests at the idle level, equal to cfg_pol (0 = low, 1 = high), whenever no word is in flight.
- R3: Transmit bits leave most significant bit first; sd_o changes on the leading edge (rising for cfg_pol=0, falling for cfg_pol=1) and is stable at the trailing edge.
- R4: Receive bits are sampled on the trailing edge (falling for cfg_pol=0, rising for cfg_pol=1) and shifted in most significant bit first; rx_data holds the word right-aligned with all bits above the word length zero.
- R5: After the last trailing edge rx_valid is high for exactly one cycle per word.
- R6: The effective word length is cfg_len limited to the range 8 to 32; a transmit word keeps only its low word-length bits.
- R7: In slave mode (cfg_master=0) an armed word waits for edges on sck_i, and edges on sck_i while no word is armed are ignored (no rx_valid, tx_ready stays high).
- R8: When cfg_idle_low equals cfg_pol (consistent only when cfg_idle_low = NOT cfg_pol) cfg_err is set and stays set until reset; while the mismatch or the flag is present tx_ready is low and no clock pulses are produced.
- R9: After reset tx_ready is 1 with a consistent configuration, rx_valid and cfg_err are 0, and in master mode the clock pin is at its idle level.
- R10: Once a word is accepted, tx_ready stays low until that word has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = drive bit clock, 0 = receive bit clock |
| cfg_pol | input | 1 | Polarity: 0 = lead rising / idle low, 1 = lead falling / idle high |
| cfg_idle_low | input | 1 | Idle-state setting, must equal NOT cfg_pol |
| cfg_len | input | 6 | Requested word length (limited to 8..32) |
| cfg_half | input | 8 | Master half bit period in system cycles (0 acts as 1) |
| tx_data | input | 32 | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block can accept a transmit word |
| rx_data | output | 32 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| cfg_err | output | 1 | Sticky idle-level/polarity mismatch flag |
| sck_o | output | 1 | Bit clock driven in master mode |
| sck_oe | output | 1 | Output enable for the bit clock pin |
| sck_i | input | 1 | Bit clock received in slave mode |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
The hardest situation to reach is the slave transfer, where bit timing comes from an asynchronous clock that passes through a synchronizer, so drive and sample happen several system cycles after the physical edges. The bench plays the remote master itself: it toggles sck_i with a half period well above the synchronizer delay, changes sd_i at each leading edge, and captures sd_o just before each trailing edge, so both directions are checked against its own bit pattern. Stray clock bursts with no armed word and a burst with the error flag set are driven to show the state machine refuses to move.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_DONE
    } gsp_state_e;
endpackage

// File: rtl/gsp_bitclk_gen.sv
module gsp_bitclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_eff;

    assign half_eff = (half == '0) ? DIV_W'(1) : half;
    assign tick     = run && (cnt == half_eff - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/gsp_sck_sync.sv
module gsp_sck_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pol,
    input  logic sck_in,
    output logic lead,
    output logic trail
);
    logic [2:0] stage;
    logic       now_act;
    logic       was_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[1:0], sck_in};
    end

    assign now_act = stage[1] ^ pol;
    assign was_act = stage[2] ^ pol;
    assign lead    = now_act && !was_act;
    assign trail   = !now_act && was_act;
endmodule

// File: rtl/gated_serial_port.sv
module gated_serial_port
    import gsp_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int MIN_LEN = 8,
    parameter int DIV_W   = 8,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_master,
    input  logic               cfg_pol,
    input  logic               cfg_idle_low,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [DIV_W-1:0]   cfg_half,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_valid,
    output logic               cfg_err,
    output logic               sck_o,
    output logic               sck_oe,
    input  logic               sck_i,
    output logic               sd_o,
    input  logic               sd_i
);
    gsp_state_e         state, state_nx;
    logic [LEN_W-1:0]   len_eff, len_q, bit_cnt;
    logic [MAX_LEN-1:0] tx_sh, rx_sh;
    logic               sck_act, sd_q;
    logic               mismatch, accept;
    logic               tick, s_lead, s_trail, lead_ev, trail_ev, run;

    assign mismatch = (cfg_idle_low == cfg_pol);
    assign len_eff  = (cfg_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) :
                      (cfg_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : cfg_len;
    assign run      = cfg_master && (state == ST_LEAD || state == ST_TRAIL);
    assign accept   = tx_valid && tx_ready;

    gsp_bitclk_gen #(.DIV_W(DIV_W)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .half  (cfg_half),
        .tick  (tick)
    );

    gsp_sck_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pol    (cfg_pol),
        .sck_in (sck_i),
        .lead   (s_lead),
        .trail  (s_trail)
    );

    assign lead_ev  = cfg_master ? tick : s_lead;
    assign trail_ev = cfg_master ? tick : s_trail;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)   state_nx = ST_LEAD;
            ST_LEAD:  if (lead_ev)  state_nx = ST_TRAIL;
            ST_TRAIL: if (trail_ev) state_nx = (bit_cnt == len_q - LEN_W'(1)) ? ST_DONE : ST_LEAD;
            ST_DONE:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // sticky configuration error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_err <= 1'b0;
        else if (mismatch) cfg_err <= 1'b1;
    end

    // shifting datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            len_q   <= LEN_W'(MIN_LEN);
            bit_cnt <= '0;
            sck_act <= 1'b0;
            sd_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    tx_sh   <= tx_data << (LEN_W'(MAX_LEN) - len_eff);
                    rx_sh   <= '0;
                    len_q   <= len_eff;
                    bit_cnt <= '0;
                end
                ST_LEAD: if (lead_ev) begin
                    sd_q    <= tx_sh[MAX_LEN-1];
                    tx_sh   <= tx_sh << 1;
                    sck_act <= cfg_master;
                end
                ST_TRAIL: if (trail_ev) begin
                    rx_sh   <= {rx_sh[MAX_LEN-2:0], sd_i};
                    bit_cnt <= bit_cnt + LEN_W'(1);
                    sck_act <= 1'b0;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_ready = (state == ST_IDLE) && !cfg_err && !mismatch;
        rx_valid = (state == ST_DONE);
        rx_data  = rx_sh;
        sck_o    = cfg_pol ^ sck_act;
        sck_oe   = cfg_master;
        sd_o     = sd_q;
    end
endmodule

// File: rtl/gsp_checker.sv
module gsp_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_master,
    input logic cfg_pol,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic cfg_err,
    input logic sck_o,
    input logic sd_o
);
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5
    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !tx_ready); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R8
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && tx_ready) |-> (sck_o == cfg_pol)); // R2
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready); // R10
    AST_DRIVE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !$stable(sd_o)) |-> (sck_o != cfg_pol)); // R3
endmodule

bind gated_serial_port gsp_checker u_chk (.*);

// File: tb/tb_gated_serial_port.sv
module tb_gated_serial_port;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        m;
        logic        pol;
        logic [5:0]  len;
        logic [7:0]  half;
        logic [31:0] tx;
        logic [31:0] rx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 6'd8,  8'd1, 32'h000000A5, 32'h0000003C},
        '{1'b1, 1'b1, 6'd8,  8'd2, 32'h00000081, 32'h0000007E},
        '{1'b1, 1'b0, 6'd16, 8'd3, 32'h0000BEEF, 32'h00001234},
        '{1'b1, 1'b1, 6'd32, 8'd1, 32'hDEADBEEF, 32'h0F0F5AA5},
        '{1'b0, 1'b0, 6'd12, 8'd6, 32'h00000ABC, 32'h000005A3},
        '{1'b0, 1'b1, 6'd24, 8'd6, 32'h00C3A5F0, 32'h000FF00F},
        '{1'b1, 1'b0, 6'd40, 8'd2, 32'hFFFFFFFF, 32'h80000001},
        '{1'b1, 1'b1, 6'd3,  8'd0, 32'h000001FF, 32'h00000096}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_master = 1'b1, cfg_pol = 1'b0, cfg_idle_low = 1'b1;
    logic [5:0]  cfg_len = 6'd8;
    logic [7:0]  cfg_half = 8'd1;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, rx_valid, cfg_err, sck_o, sck_oe, sd_o;
    logic [31:0] rx_data;
    logic        sck_i = 1'b0, sd_i_s = 1'b0, sd_i_m;
    logic        sd_i;

    int errors = 0, checks = 0;

    gated_serial_port dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_pol(cfg_pol),
        .cfg_idle_low(cfg_idle_low), .cfg_len(cfg_len), .cfg_half(cfg_half),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .cfg_err(cfg_err),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .sd_o(sd_o), .sd_i(sd_i)
    );

    assign sd_i = cfg_master ? sd_i_m : sd_i_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    // master-side monitor and remote-device model
    logic        clr = 1'b1;
    logic [31:0] pat = '0;
    int          pat_len = 8;
    int          idx, pulses, rxv_cnt, cyc, last_lead, period;
    logic        prev, norm, have_lead;
    logic [31:0] cap, rx_got;

    always @(negedge clk) begin
        cyc = cyc + 1;
        norm = sck_o ^ cfg_pol;
        if (clr) begin
            idx = pat_len - 1; pulses = 0; rxv_cnt = 0; cap = '0; rx_got = '0;
            period = 0; have_lead = 1'b0; sd_i_m = 1'b0;
        end else begin
            if (cfg_master && norm && !prev) begin
                if (have_lead && period == 0) period = cyc - last_lead;
                last_lead = cyc; have_lead = 1'b1;
                if (idx >= 0) sd_i_m = pat[idx];
                idx = idx - 1;
            end
            if (cfg_master && !norm && prev) begin
                cap = {cap[30:0], sd_o};
                pulses = pulses + 1;
            end
            if (rx_valid) begin
                rxv_cnt = rxv_cnt + 1;
                rx_got = rx_data;
            end
        end
        prev = norm;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic restart_mon();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); @(negedge clk); clr = 1'b0;
    endtask

    task automatic offer(input logic [31:0] w);
        @(negedge clk);
        tx_data = w; tx_valid = 1'b1;
        for (int k = 0; k < 50 && !tx_ready; k++) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic slave_bursts(input int n, input int h, input logic [31:0] p,
                                output logic [31:0] scap);
        scap = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sck_i = ~cfg_pol;
            sd_i_s = p[n-1-i];
            repeat (h) @(negedge clk);
            scap = {scap[30:0], sd_o};
            sck_i = cfg_pol;
            repeat (h - 1) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [31:0] lmask(input int n);
        return (n >= 32) ? 32'hFFFFFFFF : ((32'h1 << n) - 32'h1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] scap;
        int L;
        cyc = 0; last_lead = 0; prev = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 tx_ready", {31'b0, tx_ready}, 32'h1);
        check("R9 rx_valid", {31'b0, rx_valid}, 32'h0);
        check("R9 cfg_err", {31'b0, cfg_err}, 32'h0);
        check("R9 sck idle", {31'b0, sck_o}, 32'h0);
        check("R1 sck_oe master", {31'b0, sck_oe}, 32'h1);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cfg_master = VECS[v].m; cfg_pol = VECS[v].pol; cfg_idle_low = ~VECS[v].pol;
            cfg_len = VECS[v].len; cfg_half = VECS[v].half;
            sck_i = VECS[v].pol;
            L = (VECS[v].len < 8) ? 8 : (VECS[v].len > 32) ? 32 : int'(VECS[v].len);
            pat = VECS[v].rx; pat_len = L;
            repeat (6) @(negedge clk);
            restart_mon();
            offer(VECS[v].tx);
            check("R10 busy after accept", {31'b0, tx_ready}, 32'h0);
            if (VECS[v].m) begin
                for (int k = 0; k < 3000 && rxv_cnt == 0; k++) @(negedge clk);
                repeat (3) @(negedge clk);
                check("R1 pulse count", pulses, L);
                check("R1 bit period", period,
                      2 * ((VECS[v].half == 0) ? 1 : int'(VECS[v].half)));
                check("R3 R6 tx bits", cap & lmask(L), VECS[v].tx & lmask(L));
                check("R2 idle level", {31'b0, sck_o}, {31'b0, VECS[v].pol});
            end else begin
                check("R7 armed waits", {31'b0, tx_ready}, 32'h0);
                slave_bursts(L, int'(VECS[v].half), VECS[v].rx, scap);
                check("R1 sck_oe slave", {31'b0, sck_oe}, 32'h0);
                check("R3 slave tx bits", scap & lmask(L), VECS[v].tx & lmask(L));
            end
            check("R4 R6 rx word", rx_got, VECS[v].rx & lmask(L));
            check("R5 one strobe", rxv_cnt, 1);
            check("R5 ready again", {31'b0, tx_ready}, 32'h1);
        end

        // R7 stray slave clocks with no armed word
        @(negedge clk);
        cfg_master = 1'b0; cfg_pol = 1'b0; cfg_idle_low = 1'b1; sck_i = 1'b0;
        restart_mon();
        slave_bursts(10, 5, 32'h155, scap);
        check("R7 no strobe when unarmed", rxv_cnt, 0);
        check("R7 ready stays high", {31'b0, tx_ready}, 32'h1);

        // R8 configuration error
        @(negedge clk);
        cfg_master = 1'b1; cfg_pol = 1'b0; cfg_idle_low = 1'b0;
        restart_mon();
        check("R8 err set", {31'b0, cfg_err}, 32'h1);
        check("R8 ready low", {31'b0, tx_ready}, 32'h0);
        tx_data = 32'hA5; tx_valid = 1'b1;
        repeat (40) @(negedge clk);
        tx_valid = 1'b0;
        check("R8 no pulses", pulses, 0);
        check("R8 no strobe", rxv_cnt, 0);
        cfg_idle_low = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 sticky", {31'b0, cfg_err}, 32'h1);
        check("R8 still blocked", {31'b0, tx_ready}, 32'h0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 R9 cleared by reset", {31'b0, cfg_err}, 32'h0);
        check("R9 ready after reset", {31'b0, tx_ready}, 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule